// File: doc/BRIEF.md
# Gain-Control Register Target on a Two-Wire Serial Bus

This block is a bus target for a two-wire serial bus (I2C) that holds one 8-bit control word for a programmable-gain analog stage. SCL and SDA are resynchronised into the system clock. START, repeated START and STOP are recognised there. An address byte is matched against the fixed prefix `1010` followed by three strap pins, so up to eight of these targets can share one bus. A write carries a memory-address byte and then a data byte. A read returns the control word from an internal pointer that an earlier write must have loaded. SDA is driven in open-drain style: the block only ever pulls it low or releases it.

The control word drives three decoded outputs for the analog stage: a standby flag, a mute flag and a 5-bit gain code. Each gain step is 3 dB, starting at -35 dB for code 00h and reaching +25 dB at code 14h. The byte engine is a single state machine with these states:

- ST_IDLE: bus free.
- ST_ADDR: shifting in the address byte.
- ST_ADDR_ACK: acknowledge slot of the address byte.
- ST_MEM: shifting in the memory-address byte.
- ST_MEM_ACK: acknowledge slot of the memory-address byte.
- ST_DATA: shifting in a data byte.
- ST_DATA_ACK: acknowledge slot of a data byte.
- ST_TX: shifting out a read byte.
- ST_TX_ACK: the master's acknowledge slot after a read byte.
- ST_IGNORE: off the bus until the next START.

Transitions are listed below.

- START from any state goes to ST_ADDR.
- STOP from any state goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_IGNORE on a mismatch, both at the falling SCL edge after the eighth bit.
- ST_ADDR_ACK goes to ST_TX when the R/W bit is 1 and to ST_MEM when it is 0, at the falling SCL edge that ends the slot.
- ST_MEM goes to ST_MEM_ACK, and ST_MEM_ACK goes to ST_DATA.
- ST_DATA goes to ST_DATA_ACK, and ST_DATA_ACK goes back to ST_DATA.
- ST_TX goes to ST_TX_ACK.
- ST_TX_ACK goes to ST_IGNORE when the master NACKs (SDA high at the rising SCL edge), and back to ST_TX when the master ACKs, at the next falling SCL edge.

Top module: `gain_ctrl_target`

## Requirements
- R1: After reset the control word is 80h. This gives standby_o=1, mute_o=1, gain_o=00h, and sda_pull_o=0 (SDA released).
- R2: An address byte whose upper seven bits equal {4'b1010, strap_i[2:0]} is acknowledged: sda_pull_o=1 during the ninth SCL clock. With strap_i=000 the write byte is A0h and the read byte is A1h. A byte that matches a previous strap value but not the current one is not acknowledged.
- R3: A mismatched address byte is not acknowledged. After it, SDA is never pulled and all bytes are ignored until the next START, so the control word does not change.
- R4: A write is address+W, memory address F8h, then a data byte. It loads the control word, and each byte is acknowledged. Field positions in the control word: bit 7 is standby, bit 6 is stored but unused, bit 5 is mute, and bits 4:0 are the gain code.
- R5: A data byte written while the memory address is not F8h is acknowledged but leaves the control word unchanged.
- R6: A data byte whose bits 4:0 exceed 14h is acknowledged but leaves the whole control word unchanged. Code 14h itself is accepted. gain_o never exceeds 14h.
- R7: A read returns, MSB first, the control word when the pointer holds F8h and 00h for any other pointer value. The pointer is set only by the memory-address byte of a write. It survives a repeated START or a STOP and never increments.
- R8: After the master NACKs a read byte the target releases SDA and stays off the bus.
- R9: standby_o equals control bit 7, and mute_o equals bit 5 OR bit 7. gain_o equals bits 4:0 whatever the mute and standby bits are.
- R10: STOP returns the engine to idle with SDA released. A START at any point, including a repeated START in the middle of a write, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Low three address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| standby_o | output | 1 | Analog stage in standby |
| mute_o | output | 1 | Analog output muted |
| gain_o | output | 5 | Gain code, 3 dB per step from -35 dB |

## Verification
A bit counter or state that drifts by one SCL clock shows up at once as a missing or misplaced acknowledge, which the master reads in the ninth clock of the same byte. A wrong pointer or a wrongly accepted write does not show on the pins directly. It appears either in the decoded standby, mute and gain outputs right after the transaction's STOP, or in the byte returned by the next read. For that reason every write, including the rejected ones, is followed by an output check, and the pointer rules are checked through reads. The ignore state is checked by watching that SDA is never pulled during a foreign transaction.

// File: rtl/gct_pkg.sv
package gct_pkg;
    localparam int BYTE_W     = 8;
    localparam int STRAP_W    = 3;
    localparam int GAIN_W     = 5;
    localparam int CNT_W      = $clog2(BYTE_W + 1);
    localparam logic [3:0]        DEV_PREFIX = 4'b1010;
    localparam logic [BYTE_W-1:0] CTRL_ADDR  = 8'hF8;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h80;
    localparam logic [GAIN_W-1:0] GAIN_MAX   = 5'h14;
    localparam int STBY_BIT = 7;
    localparam int MUTE_BIT = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MEM,
        ST_MEM_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } state_t;
endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    // STAGES synchroniser flops plus one history flop per line
    logic [STAGES:0] scl_sh, sda_sh;
    logic scl_now, scl_prev, sda_now, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_now  = scl_sh[STAGES-1];
    assign scl_prev = scl_sh[STAGES];
    assign sda_now  = sda_sh[STAGES-1];
    assign sda_prev = sda_sh[STAGES];

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
    assign sda_bit   = sda_now;
endmodule

// File: rtl/gct_ctrl_reg.sv
module gct_ctrl_reg
    import gct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              standby_o,
    output logic              mute_o,
    output logic [GAIN_W-1:0] gain_o
);
    logic accept;

    assign accept = wr_en && (wr_ptr == CTRL_ADDR) && (wr_data[GAIN_W-1:0] <= GAIN_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= CTRL_RESET;
        else if (accept) ctrl_q <= wr_data;
    end

    assign standby_o = ctrl_q[STBY_BIT];
    assign mute_o    = ctrl_q[MUTE_BIT] | ctrl_q[STBY_BIT];
    assign gain_o    = ctrl_q[GAIN_W-1:0];
endmodule

// File: rtl/gct_fsm.sv
module gct_fsm
    import gct_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_bit,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  ctrl_q,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  ptr_q,
    output logic               sda_low,
    output state_t             state
);
    state_t             nxt;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg, txsh, rd_byte;
    logic               byte_done, addr_hit, rx_state, ack_fall;

    assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1:1] == {DEV_PREFIX, strap_i});
    assign rd_byte   = (ptr_q == CTRL_ADDR) ? ctrl_q : '0;
    assign rx_state  = (state == ST_ADDR) || (state == ST_MEM) || (state == ST_DATA);
    assign ack_fall  = scl_fall && ((state == ST_ADDR_ACK) || (state == ST_MEM_ACK) ||
                                    (state == ST_DATA_ACK) || (state == ST_TX_ACK));
    assign wr_en     = (state == ST_DATA) && byte_done;
    assign wr_data   = shreg;

    always_comb begin
        nxt = state;
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  nxt = shreg[0] ? ST_TX : ST_MEM;
                ST_MEM:      if (byte_done) nxt = ST_MEM_ACK;
                ST_MEM_ACK:  if (scl_fall)  nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  nxt = ST_DATA;
                ST_TX:       if (byte_done) nxt = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (scl_rise && sda_bit) nxt = ST_IGNORE;
                    else if (scl_fall)       nxt = ST_TX;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit counter, receive shifter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            ptr_q <= '0;
        end else begin
            if (start_det || stop_det || byte_done || ack_fall)
                cnt <= '0;
            else if (scl_rise && (rx_state || state == ST_TX))
                cnt <= cnt + 1'b1;
            if (scl_rise && rx_state)
                shreg <= {shreg[BYTE_W-2:0], sda_bit};
            if ((state == ST_MEM) && byte_done)
                ptr_q <= shreg;
        end
    end

    // SDA output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low <= 1'b0;
            txsh    <= '0;
        end else if (start_det || stop_det) begin
            sda_low <= 1'b0;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:              sda_low <= byte_done && addr_hit;
                ST_MEM, ST_DATA:      sda_low <= byte_done;
                ST_ADDR_ACK, ST_TX_ACK: begin
                    if (nxt == ST_TX) begin
                        txsh    <= rd_byte;
                        sda_low <= ~rd_byte[BYTE_W-1];
                    end else begin
                        sda_low <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (byte_done) begin
                        sda_low <= 1'b0;
                    end else begin
                        txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_low <= ~txsh[BYTE_W-2];
                    end
                end
                default: sda_low <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gain_ctrl_target.sv
module gain_ctrl_target
    import gct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic               standby_o,
    output logic               mute_o,
    output logic [GAIN_W-1:0]  gain_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic wr_en;
    logic [BYTE_W-1:0] wr_data, ptr_q, ctrl_q;
    state_t state;

    gct_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
    );

    gct_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
        .strap_i(strap_i), .ctrl_q(ctrl_q), .wr_en(wr_en), .wr_data(wr_data),
        .ptr_q(ptr_q), .sda_low(sda_pull_o), .state(state)
    );

    gct_ctrl_reg reg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr_q), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .standby_o(standby_o), .mute_o(mute_o), .gain_o(gain_o)
    );
endmodule

// File: rtl/gct_chk.sv
module gct_chk
    import gct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input state_t            state,
    input logic              sda_pull_o,
    input logic              scl_fall,
    input logic              stop_det,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic              standby_o,
    input logic              mute_o,
    input logic [GAIN_W-1:0] gain_o
);
    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_o);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_pull_o);

    // R6
    gain_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_o <= GAIN_MAX);

    // R9
    standby_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> mute_o);

    // R4
    reg_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> $past(scl_fall));

    // R2
    pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));
endmodule

bind gain_ctrl_target gct_chk chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_pull_o(sda_pull_o),
    .scl_fall(scl_fall), .stop_det(stop_det), .ctrl_q(ctrl_q),
    .standby_o(standby_o), .mute_o(mute_o), .gain_o(gain_o)
);

// File: tb/gain_ctrl_target_tb.sv
module gain_ctrl_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 5;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic sda_pull, standby, mute;
    logic [4:0] gain;
    logic sda_line;
    logic pull_seen = 1'b0;
    logic clr_seen = 1'b0;

    item_t exp_q[$];
    item_t act_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_ctrl_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .sda_pull_o(sda_pull), .standby_o(standby), .mute_o(mute), .gain_o(gain)
    );

    always @(posedge clk) begin
        if (clr_seen)      pull_seen <= 1'b0;
        else if (sda_pull) pull_seen <= 1'b1;
    end

    // monitor: compares results against the expected items in order
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a.val !== e.val) begin
                    errors++;
                    $display("FAIL %s actual %02h expected %02h", e.req, a.val, e.val);
                end
            end
        end
    end

    task automatic expect_val(input string req, input logic [7:0] v);
        item_t it;
        it.req = req; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input string req, input logic [7:0] v);
        item_t it;
        it.req = req; it.val = v;
        act_q.push_back(it);
    endtask

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q();
        ack = ~sda_line;
        q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1'b1; q();
            b[i] = sda_line;
            q(); scl_m = 1'b0;
        end
        sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    // write transaction with acknowledge checks
    task automatic wr_txn(input string req, input logic [7:0] dev, input logic [7:0] mem,
                          input logic [7:0] data);
        logic a;
        bus_start();
        send_byte(dev, a);  expect_val(req, 8'd1); observe(req, {7'd0, a});
        send_byte(mem, a);  expect_val(req, 8'd1); observe(req, {7'd0, a});
        send_byte(data, a); expect_val(req, 8'd1); observe(req, {7'd0, a});
        bus_stop();
    endtask

    task automatic rd_txn(input string req, input logic [7:0] dev, input logic set_ptr,
                          input logic [7:0] mem, input logic [7:0] expv);
        logic a;
        logic [7:0] b;
        bus_start();
        if (set_ptr) begin
            send_byte(dev & 8'hFE, a);
            send_byte(mem, a);
            bus_start();
        end
        send_byte(dev | 8'h01, a);
        recv_byte(1'b1, b);
        expect_val(req, expv); observe(req, b);
        q();
        expect_val("R8", 8'd0); observe("R8", {7'd0, sda_pull});
        bus_stop();
    endtask

    task automatic chk_outputs(input string req, input logic s, input logic m, input logic [4:0] g);
        q();
        expect_val(req, {2'b0, s, m, g[3:0]} | {3'b0, g[4], 4'b0} << 0);
        observe(req, {2'b0, standby, mute, gain[3:0]} | {3'b0, gain[4], 4'b0} << 0);
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        q();

        // R1 reset state
        expect_val("R1", 8'd0); observe("R1", {7'd0, sda_pull});
        chk_outputs("R1", 1'b1, 1'b1, 5'h00);

        // R2 R4 basic write and decoded outputs
        wr_txn("R2", 8'hA0, 8'hF8, 8'h0A);
        chk_outputs("R4", 1'b0, 1'b0, 5'h0A);

        // R7 read back through dummy write and repeated START
        rd_txn("R7", 8'hA0, 1'b1, 8'hF8, 8'h0A);

        // R6 illegal gain rejected, boundary code accepted
        wr_txn("R6", 8'hA0, 8'hF8, 8'h15);
        chk_outputs("R6", 1'b0, 1'b0, 5'h0A);
        wr_txn("R6", 8'hA0, 8'hF8, 8'h1F);
        chk_outputs("R6", 1'b0, 1'b0, 5'h0A);
        wr_txn("R6", 8'hA0, 8'hF8, 8'h14);
        chk_outputs("R6", 1'b0, 1'b0, 5'h14);

        // R5 wrong memory address leaves register alone
        wr_txn("R5", 8'hA0, 8'h10, 8'h00);
        chk_outputs("R5", 1'b0, 1'b0, 5'h14);

        // R7 pointer not F8h reads 00h, pointer kept without reload
        rd_txn("R7", 8'hA0, 1'b1, 8'h10, 8'h00);
        rd_txn("R7", 8'hA0, 1'b0, 8'h00, 8'h00);
        rd_txn("R7", 8'hA0, 1'b1, 8'hF8, 8'h14);
        rd_txn("R7", 8'hA0, 1'b0, 8'h00, 8'h14);

        // R9 mute and standby decode, bit 6 stored
        wr_txn("R9", 8'hA0, 8'hF8, 8'h2C);
        chk_outputs("R9", 1'b0, 1'b1, 5'h0C);
        wr_txn("R9", 8'hA0, 8'hF8, 8'hCC);
        chk_outputs("R9", 1'b1, 1'b1, 5'h0C);
        rd_txn("R9", 8'hA0, 1'b1, 8'hF8, 8'hCC);

        // R3 foreign address: no ACK, no pull, bytes ignored
        clr_seen = 1'b1; q(); clr_seen = 1'b0;
        bus_start();
        send_byte(8'hA2, a); expect_val("R3", 8'd0); observe("R3", {7'd0, a});
        send_byte(8'hF8, a);
        send_byte(8'h00, a);
        bus_stop();
        expect_val("R3", 8'd0); observe("R3", {7'd0, pull_seen});
        chk_outputs("R3", 1'b1, 1'b1, 5'h0C);

        // R2 new strap value changes the matched address
        strap = 3'b101;
        q();
        bus_start();
        send_byte(8'hA0, a); expect_val("R2", 8'd0); observe("R2", {7'd0, a});
        bus_stop();
        wr_txn("R2", 8'hAA, 8'hF8, 8'h03);
        chk_outputs("R2", 1'b0, 1'b0, 5'h03);

        // R10 repeated START mid-write restarts address phase
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'hF8, a);
        bus_start();
        send_byte(8'hAA, a); expect_val("R10", 8'd1); observe("R10", {7'd0, a});
        send_byte(8'hF8, a);
        send_byte(8'h05, a); expect_val("R10", 8'd1); observe("R10", {7'd0, a});
        bus_stop();
        chk_outputs("R10", 1'b0, 1'b0, 5'h05);
        expect_val("R10", 8'd0); observe("R10", {7'd0, sda_pull});

        q(); q();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule